// File: doc/BRIEF.md
# Packed-Opcode Stack Execution Core

This core runs programs whose instructions name no operands at all. Every 32-bit word fetched from instruction memory carries six 5-bit opcodes. The core works through them starting at the lowest bits and moving upward. Each opcode takes its inputs from a 16-entry hardware data stack and puts its result back on that stack. While the opcodes of one word are being worked through, the next word is already being fetched.

A literal opcode does not decode the following stream word as code. It takes that word and pushes it as data. When a word contains several literal opcodes, they claim the stream words that follow the word, one each, in slot order. Code decoding then resumes after the last claimed word.

A jump moves the top of the stack into the fetch address, and one data memory port serves loads and stores. Both memory ports are synchronous, with one cycle of read latency. A stack that overruns or runs dry latches an error flag and stops the core.

Top module: `stack_core`

## Requirements
- R1: While reset is held, `halted`, `stack_err`, `dmem_we` and `dmem_re` are 0 and `imem_addr` is 0. The first word is fetched from address 0.
- R2: Opcodes sit in six 5-bit slots of the word, bits [4:0] first and bits [29:25] last. Bits [31:30] are ignored. The encodings are: NOP=0, LIT=1, ADD=2, SUB=3, AND=4, OR=5, XOR=6, DUP=7, DROP=8, SWAP=9, LOAD=10, STORE=11, JMP=12, JZ=13, HALT=14.
- R3: ADD, SUB, AND, OR and XOR pop the top two entries and push one result. SUB pushes second-from-top minus top.
- R4: DUP pushes a copy of the top. DROP removes the top. SWAP exchanges the top two entries.
- R5: LIT pushes the next unclaimed stream word. N LIT opcodes in one word claim the N following words in slot order, and code resumes at the word after them.
- R6: STORE writes second-from-top to data address = top and pops both. LOAD replaces the top with the data word at address = top. The read takes two cycles.
- R7: JMP pops the top and continues at that instruction address. The remaining slots and any word already fetched are discarded.
- R8: JZ pops the target (top) and the condition (second). It jumps when the condition is 0 and otherwise continues with the next slot.
- R9: HALT raises `halted`, which stays high until reset. While halted, no memory strobe is issued.
- R10: The stack holds exactly 16 entries. A push onto a full stack, or an opcode that needs more entries than the stack holds, sets `stack_err` and `halted` until reset, and that opcode has no effect.
- R11: Opcode values 15 to 31 act as NOP.
- R12: `dmem_we` and `dmem_re` are never high together. An instruction request is never issued in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_req | output | 1 | Instruction read request |
| imem_addr | output | 16 | Instruction word address |
| imem_rdata | input | 32 | Instruction word, valid one cycle after the request |
| dmem_re | output | 1 | Data read strobe |
| dmem_we | output | 1 | Data write strobe |
| dmem_addr | output | 16 | Data word address (top of stack) |
| dmem_wdata | output | 32 | Store data (second-from-top) |
| dmem_rdata | input | 32 | Data read word, valid one cycle after `dmem_re` |
| halted | output | 1 | Core stopped by HALT or by a stack fault |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
Almost every internal slip in this core shows up as a wrong or missing store on the data port, usually within one word's worth of slots. A wrong slot pointer, an unflushed prefetch buffer, or a literal claimed from the wrong stream word all push the wrong value. A stack index that is off by one does the same. The result is then written out by the next STORE. A wrong depth count shows up as a `stack_err` rise that comes early or late, measured against a program that fills the stack to exactly sixteen entries and one that goes past it. A lost halt shows up right away as further strobes on either memory port.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_NOP   = 5'd0,
        OP_LIT   = 5'd1,
        OP_ADD   = 5'd2,
        OP_SUB   = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_DUP   = 5'd7,
        OP_DROP  = 5'd8,
        OP_SWAP  = 5'd9,
        OP_LOAD  = 5'd10,
        OP_STORE = 5'd11,
        OP_JMP   = 5'd12,
        OP_JZ    = 5'd13,
        OP_HALT  = 5'd14
    } op_e;

    typedef enum logic [2:0] {
        SK_NONE,
        SK_PUSH,
        SK_POP1,
        SK_POP2,
        SK_BIN,
        SK_REPL,
        SK_SWAP
    } skop_e;

endpackage

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_e             op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    // a is second-from-top, b is top
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/sc_stack.sv
module sc_stack
    import sc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  skop_e                      op,
    input  logic [XLEN-1:0]            wdata,
    output logic [XLEN-1:0]            tos,
    output logic [XLEN-1:0]            nos,
    output logic [$clog2(DEPTH+1)-1:0] cnt
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [XLEN-1:0] ent_q [DEPTH];
    logic [XLEN-1:0] ent_d [DEPTH];
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [PW-1:0]   i_new, i_top, i_sec;

    assign i_new = PW'(cnt_q);
    assign i_top = PW'(cnt_q - CW'(1));
    assign i_sec = PW'(cnt_q - CW'(2));

    assign tos = ent_q[i_top];
    assign nos = ent_q[i_sec];
    assign cnt = cnt_q;

    // the caller guarantees depth is legal for every op it issues
    always_comb begin
        ent_d = ent_q;
        cnt_d = cnt_q;
        case (op)
            SK_PUSH: begin
                ent_d[i_new] = wdata;
                cnt_d        = cnt_q + CW'(1);
            end
            SK_POP1: cnt_d = cnt_q - CW'(1);
            SK_POP2: cnt_d = cnt_q - CW'(2);
            SK_BIN: begin
                ent_d[i_sec] = wdata;
                cnt_d        = cnt_q - CW'(1);
            end
            SK_REPL: ent_d[i_top] = wdata;
            SK_SWAP: begin
                ent_d[i_top] = ent_q[i_sec];
                ent_d[i_sec] = ent_q[i_top];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            ent_q <= ent_d;
        end
    end

endmodule

// File: rtl/sc_fetch.sv
module sc_fetch #(
    parameter int            XLEN     = 32,
    parameter int            AW       = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stop,
    input  logic            redirect,
    input  logic [AW-1:0]   target,
    input  logic            take,
    input  logic [XLEN-1:0] imem_rdata,
    output logic            imem_req,
    output logic [AW-1:0]   imem_addr,
    output logic            word_vld,
    output logic [XLEN-1:0] word
);

    typedef struct packed {
        logic [AW-1:0]   pc;
        logic            infl;
        logic            vld;
        logic [XLEN-1:0] buf_w;
    } fetch_t;

    fetch_t q, d;

    assign imem_addr = q.pc;
    assign word_vld  = q.vld;
    assign word      = q.buf_w;
    // one request at a time, and only into an empty buffer
    assign imem_req  = !q.vld && !q.infl && !stop && !redirect;

    always_comb begin
        d = q;
        if (redirect) begin
            d.pc   = target;
            d.vld  = 1'b0;
            d.infl = 1'b0;
        end else begin
            d.infl = imem_req;
            if (imem_req) d.pc = q.pc + AW'(1);
            if (q.infl) begin
                d.vld   = 1'b1;
                d.buf_w = imem_rdata;
            end
            if (take) d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.pc    <= RESET_PC;
            q.infl  <= 1'b0;
            q.vld   <= 1'b0;
            q.buf_w <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/stack_core.sv
module stack_core
    import sc_pkg::*;
#(
    parameter int            XLEN     = 32,
    parameter int            AW       = 16,
    parameter int            DEPTH    = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            imem_req,
    output logic [AW-1:0]   imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic            dmem_re,
    output logic            dmem_we,
    output logic [AW-1:0]   dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            halted,
    output logic            stack_err
);

    localparam int SLOTS = XLEN / OPW;
    localparam int SW    = $clog2(SLOTS);
    localparam int CW    = $clog2(DEPTH+1);
    localparam logic [SW-1:0] LAST = SW'(SLOTS-1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] TWO  = CW'(2);

    typedef struct packed {
        logic [XLEN-1:0] ir;
        logic            ir_vld;
        logic [SW-1:0]   slot;
        logic            ld_wait;
        logic            halted;
        logic            err;
    } core_t;

    core_t q, d;

    logic            word_vld, take, lit_take, redir, adv, fault;
    logic [XLEN-1:0] word, tos, nos, alu_y, sk_wdata;
    logic [CW-1:0]   cnt;
    skop_e           sk_op;
    op_e             op;

    assign op = op_e'(q.ir[q.slot*OPW +: OPW]);

    sc_fetch #(.XLEN(XLEN), .AW(AW), .RESET_PC(RESET_PC)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop       (q.halted),
        .redirect   (redir),
        .target     (tos[AW-1:0]),
        .take       (take),
        .imem_rdata (imem_rdata),
        .imem_req   (imem_req),
        .imem_addr  (imem_addr),
        .word_vld   (word_vld),
        .word       (word)
    );

    sc_stack #(.XLEN(XLEN), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (sk_op),
        .wdata (sk_wdata),
        .tos   (tos),
        .nos   (nos),
        .cnt   (cnt)
    );

    sc_alu #(.XLEN(XLEN)) u_alu (
        .op (op),
        .a  (nos),
        .b  (tos),
        .y  (alu_y)
    );

    assign dmem_addr  = tos[AW-1:0];
    assign dmem_wdata = nos;
    assign halted     = q.halted;
    assign stack_err  = q.err;

    always_comb begin
        d        = q;
        adv      = 1'b0;
        redir    = 1'b0;
        lit_take = 1'b0;
        fault    = 1'b0;
        sk_op    = SK_NONE;
        sk_wdata = tos;
        dmem_re  = 1'b0;
        dmem_we  = 1'b0;

        if (q.ir_vld && !q.halted) begin
            case (op)
                OP_NOP: adv = 1'b1;
                OP_LIT: begin
                    if (cnt == FULL) fault = 1'b1;
                    else if (word_vld) begin
                        sk_op    = SK_PUSH;
                        sk_wdata = word;
                        lit_take = 1'b1;
                        adv      = 1'b1;
                    end
                end
                OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
                    if (cnt < TWO) fault = 1'b1;
                    else begin
                        sk_op    = SK_BIN;
                        sk_wdata = alu_y;
                        adv      = 1'b1;
                    end
                end
                OP_DUP: begin
                    if (cnt < ONE || cnt == FULL) fault = 1'b1;
                    else begin
                        sk_op = SK_PUSH;
                        adv   = 1'b1;
                    end
                end
                OP_DROP: begin
                    if (cnt < ONE) fault = 1'b1;
                    else begin
                        sk_op = SK_POP1;
                        adv   = 1'b1;
                    end
                end
                OP_SWAP: begin
                    if (cnt < TWO) fault = 1'b1;
                    else begin
                        sk_op = SK_SWAP;
                        adv   = 1'b1;
                    end
                end
                OP_LOAD: begin
                    if (cnt < ONE) fault = 1'b1;
                    else if (!q.ld_wait) begin
                        dmem_re   = 1'b1;
                        d.ld_wait = 1'b1;
                    end else begin
                        sk_op     = SK_REPL;
                        sk_wdata  = dmem_rdata;
                        d.ld_wait = 1'b0;
                        adv       = 1'b1;
                    end
                end
                OP_STORE: begin
                    if (cnt < TWO) fault = 1'b1;
                    else begin
                        dmem_we = 1'b1;
                        sk_op   = SK_POP2;
                        adv     = 1'b1;
                    end
                end
                OP_JMP: begin
                    if (cnt < ONE) fault = 1'b1;
                    else begin
                        sk_op = SK_POP1;
                        redir = 1'b1;
                    end
                end
                OP_JZ: begin
                    if (cnt < TWO) fault = 1'b1;
                    else begin
                        sk_op = SK_POP2;
                        if (nos == '0) redir = 1'b1;
                        else           adv   = 1'b1;
                    end
                end
                OP_HALT: d.halted = 1'b1;
                default: adv = 1'b1;
            endcase
        end

        if (fault) begin
            d.err    = 1'b1;
            d.halted = 1'b1;
        end

        if (adv) begin
            if (q.slot == LAST) begin
                d.ir_vld = 1'b0;
                d.slot   = '0;
            end else begin
                d.slot = q.slot + SW'(1);
            end
        end

        if (redir) begin
            d.ir_vld = 1'b0;
            d.slot   = '0;
        end

        take = lit_take;
        if (!d.ir_vld && !d.halted && !redir && word_vld && !lit_take) begin
            d.ir     = word;
            d.ir_vld = 1'b1;
            d.slot   = '0;
            take     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic clk,
    input logic rst_n,
    input logic imem_req,
    input logic dmem_re,
    input logic dmem_we,
    input logic halted,
    input logic stack_err
);

    AST_DMEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_we && dmem_re)); // R12

    AST_FETCH_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        imem_req |=> !imem_req); // R12

    AST_LOAD_TWO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_re |=> !dmem_re); // R6

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9

    AST_QUIET_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(imem_req || dmem_we || dmem_re)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err); // R10

    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |-> halted); // R10

endmodule

bind stack_core sc_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_req  (imem_req),
    .dmem_re   (dmem_re),
    .dmem_we   (dmem_we),
    .halted    (halted),
    .stack_err (stack_err)
);

// File: tb/tb_stack_core.sv
module tb_stack_core;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] NOP = 5'd0,  LIT = 5'd1,  ADD = 5'd2,  SUB = 5'd3;
    localparam logic [4:0] AND_ = 5'd4, OR_ = 5'd5,  XOR_ = 5'd6, DUP = 5'd7;
    localparam logic [4:0] DROP = 5'd8, SWAP = 5'd9, LOAD = 5'd10, STORE = 5'd11;
    localparam logic [4:0] JMP = 5'd12, JZ = 5'd13,  HALT = 5'd14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_req, dmem_re, dmem_we, halted, stack_err;
    logic [15:0] imem_addr, dmem_addr;
    logic [31:0] imem_rdata = '0, dmem_rdata = '0, dmem_wdata;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int vectors = 0;
    int fails   = 0;

    typedef struct {
        logic [15:0] a;
        logic [31:0] d;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_req   (imem_req),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_re    (dmem_re),
        .dmem_we    (dmem_we),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .halted     (halted),
        .stack_err  (stack_err)
    );

    // synchronous memories, one cycle read latency
    always @(posedge clk) begin
        if (imem_req) imem_rdata <= imem[imem_addr[5:0]];
        if (dmem_re)  dmem_rdata <= dmem[dmem_addr[5:0]];
        if (dmem_we)  dmem[dmem_addr[5:0]] <= dmem_wdata;
    end

    function automatic logic [31:0] w6(input logic [4:0] s0, s1, s2, s3, s4, s5);
        return {2'b00, s5, s4, s3, s2, s1, s0};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_store(input logic [15:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        e.a = a; e.d = d; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: every store is popped and compared against the scoreboard
    always @(negedge clk) begin
        if (rst_n && dmem_we) begin
            vectors++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL unexpected store: actual addr %0d data %0h expected none",
                         dmem_addr, dmem_wdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (dmem_addr !== e.a || dmem_wdata !== e.d) begin
                    fails++;
                    $display("FAIL %s store: actual addr %0d data %0h expected addr %0d data %0h",
                             e.tag, dmem_addr, dmem_wdata, e.a, e.d);
                end
            end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i] = '0;
            dmem[i] = '0;
        end
    endtask

    task automatic run(input string tag, input logic exp_err);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (halted) break;
        end
        repeat (4) @(negedge clk);
        check(tag, "pending stores", sb.size(), 0);
        check(tag, "halted", {31'd0, halted}, 32'd1);
        check(tag, "stack_err", {31'd0, stack_err}, {31'd0, exp_err});
        sb.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        clear_mem();
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "halted", {31'd0, halted}, 32'd0);
        check("R1", "stack_err", {31'd0, stack_err}, 32'd0);
        check("R1", "imem_addr", {16'd0, imem_addr}, 32'd0);
        check("R1", "dmem strobes", {30'd0, dmem_we, dmem_re}, 32'd0);

        // R2 R3 R5: three literals, add, store
        clear_mem();
        imem[0] = w6(LIT, LIT, ADD, LIT, STORE, HALT);
        imem[1] = 7; imem[2] = 5; imem[3] = 40;
        expect_store(40, 12, "R5");
        run("R2", 1'b0);

        // R3: sub, xor, and, or
        clear_mem();
        imem[0]  = w6(LIT, LIT, SUB, LIT, STORE, NOP);
        imem[1]  = 20; imem[2] = 3; imem[3] = 41;
        imem[4]  = w6(LIT, LIT, XOR_, LIT, STORE, NOP);
        imem[5]  = 32'hF0F0; imem[6] = 32'h0FF0; imem[7] = 42;
        imem[8]  = w6(LIT, LIT, AND_, LIT, STORE, NOP);
        imem[9]  = 32'hFF0F; imem[10] = 32'h0FF0; imem[11] = 43;
        imem[12] = w6(LIT, LIT, OR_, LIT, STORE, NOP);
        imem[13] = 32'hF000; imem[14] = 32'h000F; imem[15] = 44;
        imem[16] = w6(HALT, NOP, NOP, NOP, NOP, NOP);
        expect_store(41, 17, "R3");
        expect_store(42, 32'hFF00, "R3");
        expect_store(43, 32'h0F00, "R3");
        expect_store(44, 32'hF00F, "R3");
        run("R3", 1'b0);

        // R4: swap, dup, drop
        clear_mem();
        imem[0] = w6(LIT, LIT, SWAP, LIT, STORE, NOP);
        imem[1] = 3; imem[2] = 9; imem[3] = 50;
        imem[4] = w6(DUP, LIT, STORE, LIT, DROP, NOP);
        imem[5] = 51; imem[6] = 77;
        imem[7] = w6(LIT, STORE, HALT, NOP, NOP, NOP);
        imem[8] = 52;
        expect_store(50, 3, "R4");
        expect_store(51, 9, "R4");
        expect_store(52, 9, "R4");
        run("R4", 1'b0);

        // R6: load then store
        clear_mem();
        dmem[10] = 1234;
        imem[0] = w6(LIT, LOAD, LIT, STORE, HALT, NOP);
        imem[1] = 10; imem[2] = 53;
        expect_store(53, 1234, "R6");
        run("R6", 1'b0);

        // R7: jump discards rest of word and the prefetched word
        clear_mem();
        imem[0]  = w6(LIT, JMP, LIT, STORE, HALT, NOP);
        imem[1]  = 8;
        imem[2]  = w6(LIT, LIT, STORE, HALT, NOP, NOP);
        imem[3]  = 66; imem[4] = 60;
        imem[8]  = w6(LIT, LIT, STORE, HALT, NOP, NOP);
        imem[9]  = 99; imem[10] = 54;
        expect_store(54, 99, "R7");
        run("R7", 1'b0);

        // R8: jz not taken then taken
        clear_mem();
        imem[0]  = w6(LIT, LIT, JZ, LIT, LIT, STORE);
        imem[1]  = 5; imem[2] = 20; imem[3] = 111; imem[4] = 55;
        imem[5]  = w6(LIT, LIT, JZ, HALT, NOP, NOP);
        imem[6]  = 0; imem[7] = 12;
        imem[12] = w6(LIT, LIT, STORE, HALT, NOP, NOP);
        imem[13] = 222; imem[14] = 56;
        expect_store(55, 111, "R8");
        expect_store(56, 222, "R8");
        run("R8", 1'b0);

        // R9: halt stops everything that follows
        clear_mem();
        imem[0] = w6(HALT, LIT, LIT, STORE, NOP, NOP);
        imem[1] = 1; imem[2] = 2;
        run("R9", 1'b0);
        check("R9", "imem_req while halted", {31'd0, imem_req}, 32'd0);

        // R10: exactly sixteen entries is legal
        clear_mem();
        imem[0] = w6(LIT, DUP, DUP, DUP, DUP, DUP);
        imem[1] = 5;
        imem[2] = w6(DUP, DUP, DUP, DUP, DUP, DUP);
        imem[3] = w6(DUP, DUP, DUP, LIT, STORE, HALT);
        imem[4] = 57;
        expect_store(57, 5, "R10");
        run("R10", 1'b0);

        // R10: seventeenth push faults
        clear_mem();
        imem[0] = w6(LIT, DUP, DUP, DUP, DUP, DUP);
        imem[1] = 5;
        imem[2] = w6(DUP, DUP, DUP, DUP, DUP, DUP);
        imem[3] = w6(DUP, DUP, DUP, DUP, DUP, DUP);
        imem[4] = w6(LIT, LIT, STORE, HALT, NOP, NOP);
        imem[5] = 5; imem[6] = 6;
        run("R10", 1'b1);

        // R10: underflow on empty stack
        clear_mem();
        imem[0] = w6(ADD, LIT, LIT, STORE, HALT, NOP);
        imem[1] = 4; imem[2] = 59;
        run("R10", 1'b1);

        // R11: undefined opcodes are no-ops
        clear_mem();
        imem[0] = w6(LIT, 5'd31, LIT, 5'd20, STORE, HALT);
        imem[1] = 7; imem[2] = 58;
        expect_store(58, 7, "R11");
        run("R11", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule